// File: doc/BRIEF.md
# Random Number Output and Alarm Status Register Front End

This block is the register-side face of a hardware random number generator. Software reads a 128-bit random datum as four 32-bit words. It learns that a fresh datum is waiting from a ready flag in a status register. It hands the datum back by writing one to that flag, and that write also asks for the next datum. The same status register collects sticky alarm events raised by the statistical health-test logic. Each event can be routed to a single interrupt line through a per-event enable held in the control register.

The entropy source sits outside the block and streams 128-bit words over a valid/ready pair. The block asserts `src_ready` only while a refill is in progress and the programmed minimum cycle count has elapsed. A word moves only in a cycle where `src_valid` and `src_ready` are both high. The source may hold `src_valid` low for as long as it likes; it must keep `src_data` stable while `src_valid` is high and unaccepted. If nothing arrives by the programmed maximum, the block declares the old datum ready again rather than stall software.

The register bus is a plain 32-bit one: byte address, write strobe, write data, and read data that is combinational from the address. The two low address bits are ignored.

Top module: `rng_csr_front`

## Requirements
- R1: After reset every register reads zero except the revision register, and `irq` and `src_ready` are low.
- R2: Registers by word offset:
  - 0x18 keeps bits 31:16 (maximum refill cycles) and 7:0 (minimum refill cycles), and the rest reads zero.
  - 0x1C keeps bits 7:0 (alarm threshold).
  - 0x14 keeps only bit 10 (generation enable) and bits 7:1 (interrupt enables).
  - 0x7C reads {4'b0, major, minor, patch, 16'b0} and ignores writes.
  - Unmapped offsets read zero.
- R3: Setting control bit 10 while it is clear, or writing 1 to status bit 0 while bit 10 is set, starts a refill at that clock edge (edge 0). Status bit 0 (ready) cannot rise before edge min+1.
- R4: `src_ready` is high exactly while a refill runs and at least `min` cycles have passed. A word is captured at the edge where `src_valid` and `src_ready` are both high, and ready rises at that same edge. Word k at offset 4k (k = 0..3) reads `src_data[32k+31:32k]`.
- R5: If no word is accepted, ready rises at edge max+1 (or min+1 if that is later), and the previous words are offered again.
- R6: Writing 1 to status bit 0 while enabled clears ready at once. While ready is low the four output words read zero.
- R7: A pulse on `alarm_ev[j]` sets status bit j+1, and the bit stays set until a write of 1 to that bit. The bits, from 1 to 7, are shutdown overflow, stuck output, noise, run, long run, poker and monobit. Writing 1 to other bits leaves it set.
- R8: `irq` is high when some status bit n in 1..7 and control bit n are both set. Ready never raises `irq`.
- R9: Writing control with bit 10 clear stops any refill, clears ready and drops `src_ready`. A status bit 0 write while disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_ev | input | 7 | One-cycle health-test event pulses, bit j for status bit j+1 |
| src_valid | input | 1 | Entropy source holds a word |
| src_ready | output | 1 | Block will accept a word this cycle |
| src_data | input | 32*WORDS | Entropy word |
| irq | output | 1 | Alarm interrupt |

## Verification
A refill counter that starts or stops at the wrong edge shows up in the ready bit of the status register. It moves ready earlier or later than edge min+1 or max+1, so the error is visible on the first read after the expected edge. A capture register that loads when no handshake happened shows up as changed output words after a timeout refill, on the next read of offsets 0x00 to 0x0C. A sticky status bit that drops or an enable that is wired to the wrong event shows on `irq` in the cycle after the event or after the control write.

// File: rtl/rng_csr_pkg.sv
`timescale 1ns/1ps
package rng_csr_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned N_EV    = 7;   // status bits 1..7
  localparam int unsigned EN_BIT  = 10;  // generation enable in control

  // word indices (byte offset / 4)
  localparam int unsigned IDX_STS = 4;
  localparam int unsigned IDX_CTL = 5;
  localparam int unsigned IDX_CFG = 6;
  localparam int unsigned IDX_ALM = 7;
  localparam int unsigned IDX_REV = 31;

  function automatic logic [REG_W-1:0] rev_word(input int unsigned maj,
                                                 input int unsigned mnr,
                                                 input int unsigned pat);
    return {4'h0, 4'(maj), 4'(mnr), 4'(pat), 16'h0000};
  endfunction
endpackage

// File: rtl/rng_status_bank.sv
`timescale 1ns/1ps
module rng_status_bank #(
  parameter int unsigned N_EV = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev,
  input  logic            clr_we,
  input  logic [N_EV-1:0] clr_mask,
  input  logic [N_EV-1:0] ie,
  output logic [N_EV-1:0] sts,
  output logic            irq
);
  logic [N_EV-1:0] sts_q;

  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= ev[i] | (sts_q[i] & ~(clr_we & clr_mask[i]));
    end

    // R7
    ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> sts_q[i]);
    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !(clr_we && clr_mask[i])) |=> sts_q[i]);
  end

  assign sts = sts_q;
  assign irq = |(sts_q & ie);
endmodule

// File: rtl/rng_refill_ctrl.sv
`timescale 1ns/1ps
module rng_refill_ctrl #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned MINC_W = 8,
  parameter int unsigned MAXC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_start,
  input  logic              fill_stop,
  input  logic [MINC_W-1:0] min_cyc,
  input  logic [MAXC_W-1:0] max_cyc,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              data_rdy,
  output logic [DATA_W-1:0] data_q
);
  logic              filling;
  logic [MAXC_W-1:0] cnt_q;
  logic              min_hit, max_hit, take;

  assign min_hit   = cnt_q >= MAXC_W'(min_cyc);
  assign max_hit   = cnt_q >= max_cyc;
  assign src_ready = filling & min_hit;
  assign take      = src_ready & src_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling  <= 1'b0;
      data_rdy <= 1'b0;
      cnt_q    <= '0;
      data_q   <= '0;
    end else if (fill_stop) begin
      filling  <= 1'b0;
      data_rdy <= 1'b0;
      cnt_q    <= '0;
    end else if (fill_start) begin
      filling  <= 1'b1;
      data_rdy <= 1'b0;
      cnt_q    <= '0;
    end else if (filling) begin
      if (take) begin
        data_q   <= src_data;
        data_rdy <= 1'b1;
        filling  <= 1'b0;
      end else if (min_hit && max_hit) begin
        data_rdy <= 1'b1;
        filling  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  rdy_after_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> ($past(cnt_q) >= MAXC_W'($past(min_cyc))));
  // R5
  reuse_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_rdy) && !$past(take)) |-> $stable(data_q));
  // R6
  rdy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |-> !filling);
  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_stop |=> (!data_rdy && !src_ready));
endmodule

// File: rtl/rng_csr_front.sv
`timescale 1ns/1ps
module rng_csr_front
  import rng_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned WORDS     = 4,   // at most 4: status sits at index 4
  parameter int unsigned MINC_W    = 8,
  parameter int unsigned MAXC_W    = 16,
  parameter int unsigned REV_MAJOR = 2,
  parameter int unsigned REV_MINOR = 1,
  parameter int unsigned REV_PATCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic [N_EV-1:0]       alarm_ev,
  input  logic                  src_valid,
  output logic                  src_ready,
  input  logic [WORDS*REG_W-1:0] src_data,
  output logic                  irq
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned DATA_W = WORDS * REG_W;
  localparam logic [REG_W-1:0] REV_VAL = rev_word(REV_MAJOR, REV_MINOR, REV_PATCH);

  logic [IDX_W-1:0]  widx;
  logic              wr_sts, wr_ctl, wr_cfg, wr_alm;
  logic              ctl_en_q;
  logic [N_EV-1:0]   ctl_ie_q;
  logic [MAXC_W-1:0] max_q;
  logic [MINC_W-1:0] min_q;
  logic [7:0]        alm_q;
  logic              fill_start, fill_stop, data_rdy;
  logic [DATA_W-1:0] data_q;
  logic [N_EV-1:0]   sts_ev;
  logic              unused_bits;

  assign widx   = bus_addr[ADDR_W-1:2];
  assign wr_sts = bus_we && (widx == IDX_W'(IDX_STS));
  assign wr_ctl = bus_we && (widx == IDX_W'(IDX_CTL));
  assign wr_cfg = bus_we && (widx == IDX_W'(IDX_CFG));
  assign wr_alm = bus_we && (widx == IDX_W'(IDX_ALM));
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[15:11], bus_wdata[9:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en_q <= 1'b0;
      ctl_ie_q <= '0;
      max_q    <= '0;
      min_q    <= '0;
      alm_q    <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_en_q <= bus_wdata[EN_BIT];
        ctl_ie_q <= bus_wdata[N_EV:1];
      end
      if (wr_cfg) begin
        max_q <= bus_wdata[16 +: MAXC_W];
        min_q <= bus_wdata[0 +: MINC_W];
      end
      if (wr_alm) alm_q <= bus_wdata[7:0];
    end
  end

  assign fill_stop  = wr_ctl && !bus_wdata[EN_BIT];
  assign fill_start = (wr_ctl && bus_wdata[EN_BIT] && !ctl_en_q) ||
                      (wr_sts && bus_wdata[0] && ctl_en_q);

  rng_refill_ctrl #(
    .DATA_W (DATA_W),
    .MINC_W (MINC_W),
    .MAXC_W (MAXC_W)
  ) u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_start (fill_start),
    .fill_stop  (fill_stop),
    .min_cyc    (min_q),
    .max_cyc    (max_q),
    .src_valid  (src_valid),
    .src_ready  (src_ready),
    .src_data   (src_data),
    .data_rdy   (data_rdy),
    .data_q     (data_q)
  );

  rng_status_bank #(
    .N_EV (N_EV)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (alarm_ev),
    .clr_we   (wr_sts),
    .clr_mask (bus_wdata[N_EV:1]),
    .ie       (ctl_ie_q),
    .sts      (sts_ev),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (widx == IDX_W'(k)) bus_rdata = data_q[k*REG_W +: REG_W] & {REG_W{data_rdy}};
    end
    if (widx == IDX_W'(IDX_STS)) bus_rdata = {{(REG_W-N_EV-1){1'b0}}, sts_ev, data_rdy};
    if (widx == IDX_W'(IDX_CTL)) begin
      bus_rdata[EN_BIT]   = ctl_en_q;
      bus_rdata[N_EV:1]   = ctl_ie_q;
    end
    if (widx == IDX_W'(IDX_CFG)) begin
      bus_rdata[16 +: MAXC_W] = max_q;
      bus_rdata[0 +: MINC_W]  = min_q;
    end
    if (widx == IDX_W'(IDX_ALM)) bus_rdata[7:0] = alm_q;
    if (widx == IDX_W'(IDX_REV)) bus_rdata = REV_VAL;
  end

  // R8
  ready_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ev == '0) |-> !irq);
  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en_q |-> (!data_rdy && !src_ready));
endmodule

// File: tb/rng_csr_front_tb.sv
`timescale 1ns/1ps
module rng_csr_front_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [6:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [6:0]   alarm_ev = '0;
  logic         src_valid = 1'b0;
  logic         src_ready;
  logic [127:0] src_data = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rng_csr_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_ev(alarm_ev),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .irq(irq)
  );

  // {addr, write data, expected read-back}
  localparam logic [71:0] TBL [7] = '{
    {8'h18, 32'hFFFF_FFFF, 32'hFFFF_00FF},
    {8'h18, 32'h000A_0003, 32'h000A_0003},
    {8'h1C, 32'h0000_1234, 32'h0000_0034},
    {8'h7C, 32'h0000_0000, 32'h0213_0000},
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h14, 32'hFFFF_F0FE, 32'h0000_00FE},
    {8'h14, 32'h0000_0000, 32'h0000_0000}
  };

  localparam logic [127:0] D1 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
  localparam logic [127:0] D2 = 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_0123_4567;
  localparam logic [127:0] D3 = 128'hA5A5_5A5A_0F0F_F0F0_1357_9BDF_2468_ACE0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic chk_words(input string req, input logic [127:0] exp);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(7'(4*k), v);
      chk(req, v, exp[32*k +: 32]);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(7'(4*a), v);
      chk("R1", v, 32'h0);
    end
    rd(7'h7C, v); chk("R1 rev", v, 32'h0213_0000);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 src_ready", {31'b0, src_ready}, 32'h0);

    // R2: register map walk
    for (int i = 0; i < 7; i++) begin
      wr(TBL[i][70:64], TBL[i][63:32]);
      rd(TBL[i][70:64], v);
      chk("R2", v, TBL[i][31:0]);
    end

    // R3/R4: enable with min 3, max 10, source ready to send
    src_valid = 1'b1; src_data = D1;
    wr(7'h18, 32'h000A_0003);
    wr(7'h14, 32'h0000_0400);           // edge 0
    repeat (2) @(negedge clk);          // edge 2
    chk("R4 src_ready before min", {31'b0, src_ready}, 32'h0);
    @(negedge clk);                     // edge 3
    rd(7'h10, v); chk("R3 ready before min+1", v, 32'h0);
    chk("R4 src_ready at min", {31'b0, src_ready}, 32'h1);
    @(negedge clk);                     // edge 4
    rd(7'h10, v); chk("R3 ready at min+1", v, 32'h1);
    chk_words("R4 words", D1);

    // R5/R6: timeout with no source word, min 2, max 5
    src_valid = 1'b0; src_data = D2;
    wr(7'h18, 32'h0005_0002);
    wr(7'h10, 32'h0000_0001);           // edge 0
    rd(7'h10, v); chk("R6 ready cleared", v, 32'h0);
    chk_words("R6 words hidden", 128'h0);
    repeat (5) @(negedge clk);          // edge 5
    rd(7'h10, v); chk("R5 ready before max+1", v, 32'h0);
    @(negedge clk);                     // edge 6
    rd(7'h10, v); chk("R5 ready at max+1", v, 32'h1);
    chk_words("R5 reused words", D1);

    // R8: ready alone with all enables set
    wr(7'h14, 32'h0000_04FE);
    chk("R8 ready no irq", {31'b0, irq}, 32'h0);

    // R7/R8: noise event (status bit 3)
    @(negedge clk); alarm_ev = 7'b000_0100;
    @(negedge clk); alarm_ev = 7'b0;
    rd(7'h10, v); chk("R7 event sets", v, 32'h9);
    chk("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(7'h14, 32'h0000_0400);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(7'h10, 32'h0000_00F6);
    rd(7'h10, v); chk("R7 other ones keep bit", v, 32'h9);
    wr(7'h10, 32'h0000_0008);
    rd(7'h10, v); chk("R7 w1c", v, 32'h1);

    // R3/R4: ack with min 0 and source waiting
    wr(7'h18, 32'h0005_0000);
    src_valid = 1'b1; src_data = D3;
    wr(7'h10, 32'h0000_0001);           // edge 0
    @(negedge clk);                     // edge 1
    rd(7'h10, v); chk("R3 ready at edge 1", v, 32'h1);
    chk_words("R4 new words", D3);

    // R9: disable, then ack while disabled
    wr(7'h14, 32'h0000_0000);
    rd(7'h10, v); chk("R9 ready cleared", v, 32'h0);
    chk("R9 src_ready low", {31'b0, src_ready}, 32'h0);
    chk_words("R9 words hidden", 128'h0);
    wr(7'h10, 32'h0000_0001);
    repeat (10) @(negedge clk);
    rd(7'h10, v); chk("R9 ack ignored", v, 32'h0);
    chk("R9 src_ready stays low", {31'b0, src_ready}, 32'h0);

    summary();
  end
endmodule